// File: doc/BRIEF.md
# Watch Timer with Programmable Reload Interval

This block is a watch timer for a small microcontroller. It counts ticks of a selectable timebase. The timebase is either a slow sub-clock tick or the main-clock tick divided by one of three powers of two. The count passes through a binary prescaler and then into a small reload counter. At the end of a selected interval the block sets an interrupt flag and drives an interrupt request for as long as the flag stays set.

Software reaches the block through a byte-wide register port with one select line. Select 0 is a mode register that holds the enable, the flag, the interval choice and the timebase choice. Select 1 works differently for writes and reads. A write loads the reload value and can also clear both counters. A read returns the live value of the reload counter. Everything runs on one system clock, and both timebases arrive as single-cycle tick enables.

Top module: `wtimer_top`

## Requirements
- R1: After reset, the mode register reads 0x00, the counter register reads 0x00, irq is 0 and the reload value is 127.
- R2: Mode bits [1:0] pick the timebase: 00 = sub_tick, 01 = main_tick/2^DIV_W, 10 = main_tick/2^(DIV_W-1), 11 = main_tick/2^(DIV_W-2).
- R3: Mode bits [3:2] pick the interval in timebase ticks: 00 = 2^(PRE_W-3), 01 = 2^(PRE_W-1), 10 = 2^PRE_W.
- R4: With mode bits [3:2] = 11, the interval is 2^PRE_W*(reload+1) ticks. Each prescaler wrap advances the reload counter. A wrap that finds the counter equal to the reload value returns it to 0 and ends the interval.
- R5: A read has one cycle of latency. Select 0 returns {enable, 0, 0, flag, interval select, timebase select}. Select 1 returns the reload counter, with bit 7 reading 0.
- R6: While mode bit 7 (enable) is 0, the prescaler, the reload counter and the main divider are held at 0. Setting enable again restarts a full interval.
- R7: A select-1 write always loads bits [6:0] as the reload value. When bit 7 of that write is 1, it also clears the prescaler and the reload counter.
- R8: The flag (mode bit 4) is set at the end of each interval, and irq equals the flag.
- R9: The flag is cleared by int_ack or by a mode write with bit 4 = 0. A mode write with bit 4 = 1 never sets it. If an interval ends in the same cycle as a clear, the flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sub_tick | input | 1 | Sub-clock tick enable |
| main_tick | input | 1 | Main-clock tick enable, fed to the divider |
| reg_sel | input | 1 | Register select: 0 mode, 1 interval/counter |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered read data |
| int_ack | input | 1 | Interrupt acknowledge, clears the flag |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with PRE_W = 6 and DIV_W = 3. That shortens the intervals to 8, 32 and 64 ticks and the dividers to 8, 4 and 2. Every timebase and interval select can then be measured as an exact cycle distance between two flag sets. The reload mode is swept over several reload values, including the reset value of 127, at 64 to 8192 ticks per interval. Counter read-back, clear-on-write and enable restart are checked at exact tick counts.

// File: rtl/wt_pkg.sv
package wt_pkg;
  typedef enum logic [1:0] {
    CSEL_SUB    = 2'b00,
    CSEL_DIV_HI = 2'b01,
    CSEL_DIV_MD = 2'b10,
    CSEL_DIV_LO = 2'b11
  } csel_t;

  typedef enum logic [1:0] {
    ISEL_SHORT  = 2'b00,
    ISEL_MID    = 2'b01,
    ISEL_FULL   = 2'b10,
    ISEL_RELOAD = 2'b11
  } isel_t;

  localparam int EN_BIT   = 7;
  localparam int FLAG_BIT = 4;
  localparam int ISEL_LO  = 2;
  localparam int CSEL_LO  = 0;
  localparam int CLR_BIT  = 7;
endpackage

// File: rtl/wt_clk_sel.sv
module wt_clk_sel
  import wt_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  run,
  input  logic  sub_tick,
  input  logic  main_tick,
  input  csel_t csel,
  output logic  wck
);
  logic [DIV_W-1:0] div_q;
  logic [2:0]       div_tap;
  logic             sel_tick;

  always_ff @(posedge clk) begin
    if (rst || !run) div_q <= '0;
    else if (main_tick) div_q <= div_q + 1'b1;
  end

  // tap g divides by 2^(DIV_W-g)
  for (genvar g = 0; g < 3; g++) begin : g_tap
    localparam int K = DIV_W - g;
    assign div_tap[g] = main_tick && (&div_q[K-1:0]);
  end

  always_comb begin
    unique case (csel)
      CSEL_SUB:    sel_tick = sub_tick;
      CSEL_DIV_HI: sel_tick = div_tap[0];
      CSEL_DIV_MD: sel_tick = div_tap[1];
      default:     sel_tick = div_tap[2];
    endcase
  end

  assign wck = run && sel_tick;

  // R2: a divided timebase never ticks without a main tick
  p_no_tick_without_main_r2: assert property (@(posedge clk) disable iff (rst)
    (csel != CSEL_SUB && !main_tick) |-> !wck);

  // R6: divider held while disabled
  p_div_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !run |=> div_q == '0);
endmodule

// File: rtl/wt_chain.sv
module wt_chain
  import wt_pkg::*;
#(
  parameter int PRE_W = 14,
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             clr,
  input  logic             wck,
  input  isel_t            isel,
  input  logic [CNT_W-1:0] reload,
  output logic [CNT_W-1:0] rc_q,
  output logic             intv
);
  localparam int TAP_S = PRE_W - 3;
  localparam int TAP_M = PRE_W - 1;

  logic [PRE_W-1:0] pre_q;
  logic             end_s, end_m, end_f, rc_hit, end_sel;

  assign end_s  = wck && (&pre_q[TAP_S-1:0]);
  assign end_m  = wck && (&pre_q[TAP_M-1:0]);
  assign end_f  = wck && (&pre_q);
  assign rc_hit = (rc_q == reload);

  always_comb begin
    unique case (isel)
      ISEL_SHORT: end_sel = end_s;
      ISEL_MID:   end_sel = end_m;
      ISEL_FULL:  end_sel = end_f;
      default:    end_sel = end_f && rc_hit;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || !run || clr) begin
      pre_q <= '0;
      rc_q  <= '0;
      intv  <= 1'b0;
    end else begin
      if (wck) pre_q <= pre_q + 1'b1;
      if (end_f) rc_q <= rc_hit ? '0 : rc_q + 1'b1;
      intv <= end_sel;
    end
  end

  // R4: reaching the reload value returns the counter to zero on the next wrap
  p_reload_wrap_r4: assert property (@(posedge clk) disable iff (rst)
    (run && !clr && end_f && rc_q == reload) |=> rc_q == '0);

  // R6: counters held while disabled
  p_hold_off_r6: assert property (@(posedge clk) disable iff (rst)
    !run |=> (pre_q == '0 && rc_q == '0 && !intv));

  // R7: clear command zeroes both stages
  p_clear_r7: assert property (@(posedge clk) disable iff (rst)
    clr |=> (pre_q == '0 && rc_q == '0));
endmodule

// File: rtl/wt_regs.sv
module wt_regs
  import wt_pkg::*;
#(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_sel,
  input  logic             reg_we,
  input  logic [7:0]       reg_wdata,
  input  logic             int_ack,
  input  logic             intv,
  input  logic [CNT_W-1:0] rc,
  output logic             run,
  output csel_t            csel,
  output isel_t            isel,
  output logic [CNT_W-1:0] reload,
  output logic             clr,
  output logic             flag,
  output logic [7:0]       reg_rdata
);
  logic mode_wr, intv_wr;
  logic unused_mode_bits;

  assign mode_wr = reg_we && !reg_sel;
  assign intv_wr = reg_we && reg_sel;
  assign clr     = intv_wr && reg_wdata[CLR_BIT];
  assign unused_mode_bits = ^reg_wdata[6:5];

  always_ff @(posedge clk) begin
    if (rst) begin
      run  <= 1'b0;
      csel <= CSEL_SUB;
      isel <= ISEL_SHORT;
    end else if (mode_wr) begin
      run  <= reg_wdata[EN_BIT];
      csel <= csel_t'(reg_wdata[CSEL_LO +: 2]);
      isel <= isel_t'(reg_wdata[ISEL_LO +: 2]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) reload <= '1;
    else if (intv_wr) reload <= reg_wdata[CNT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) flag <= 1'b0;
    else if (intv) flag <= 1'b1;
    else if (int_ack || (mode_wr && !reg_wdata[FLAG_BIT])) flag <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= 8'h00;
    else if (reg_sel) reg_rdata <= {{(8-CNT_W){1'b0}}, rc};
    else reg_rdata <= {run, 2'b00, flag, isel, csel};
  end

  // R9: set wins over any clear
  p_set_wins_r9: assert property (@(posedge clk) disable iff (rst)
    intv |=> flag);
  // R9: acknowledge clears when no new interval ends
  p_ack_clears_r9: assert property (@(posedge clk) disable iff (rst)
    (int_ack && !intv) |=> !flag);
  // R9: writing one to the flag bit never sets it
  p_wr1_noset_r9: assert property (@(posedge clk) disable iff (rst)
    (mode_wr && reg_wdata[FLAG_BIT] && !flag && !intv) |=> !flag);
  // R5: counter read has bit 7 clear
  p_rd_msb_r5: assert property (@(posedge clk) disable iff (rst)
    reg_sel |=> !reg_rdata[7]);
endmodule

// File: rtl/wtimer_top.sv
module wtimer_top
  import wt_pkg::*;
#(
  parameter int PRE_W = 14,
  parameter int DIV_W = 8,
  parameter int CNT_W = 7
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sub_tick,
  input  logic       main_tick,
  input  logic       reg_sel,
  input  logic       reg_we,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       int_ack,
  output logic       irq
);
  logic             run, clr, wck, intv, flag;
  csel_t            csel;
  isel_t            isel;
  logic [CNT_W-1:0] reload, rc;

  wt_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst(rst), .reg_sel(reg_sel), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .int_ack(int_ack), .intv(intv), .rc(rc),
    .run(run), .csel(csel), .isel(isel), .reload(reload), .clr(clr),
    .flag(flag), .reg_rdata(reg_rdata)
  );

  wt_clk_sel #(.DIV_W(DIV_W)) u_clk (
    .clk(clk), .rst(rst), .run(run), .sub_tick(sub_tick),
    .main_tick(main_tick), .csel(csel), .wck(wck)
  );

  wt_chain #(.PRE_W(PRE_W), .CNT_W(CNT_W)) u_chain (
    .clk(clk), .rst(rst), .run(run), .clr(clr), .wck(wck), .isel(isel),
    .reload(reload), .rc_q(rc), .intv(intv)
  );

  assign irq = flag;

  // R8: a completed interval raises the request on the next cycle
  p_irq_follows_r8: assert property (@(posedge clk) disable iff (rst)
    intv |=> irq);
endmodule

// File: tb/wtimer_top_tb_top.sv
module wtimer_top_tb_top;
  localparam int PRE_W = 6;
  localparam int DIV_W = 3;
  localparam int CNT_W = 7;
  localparam int P_S = 1 << (PRE_W - 3);
  localparam int P_M = 1 << (PRE_W - 1);
  localparam int P_F = 1 << PRE_W;

  logic clk = 1'b0, rst = 1'b1;
  logic sub_tick = 0, main_tick = 0, reg_sel = 0, reg_we = 0, int_ack = 0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic irq;
  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;

  wtimer_top #(.PRE_W(PRE_W), .DIV_W(DIV_W), .CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst(rst), .sub_tick(sub_tick), .main_tick(main_tick),
    .reg_sel(reg_sel), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .int_ack(int_ack), .irq(irq)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wreg(input logic sel, input logic [7:0] d);
    reg_sel = sel; reg_we = 1; reg_wdata = d;
    @(negedge clk);
    reg_we = 0; reg_sel = 0;
  endtask

  task automatic rreg(input logic sel, output logic [7:0] d);
    reg_sel = sel;
    @(negedge clk);
    d = reg_rdata;
    reg_sel = 0;
  endtask

  task automatic ack();
    int_ack = 1; @(negedge clk); int_ack = 0;
  endtask

  // single sub ticks, three cycles apart; returns tick index at which irq rose
  task automatic ticks_to_flag(input int maxn, output int n);
    n = 0;
    for (int i = 1; i <= maxn; i++) begin
      sub_tick = 1; @(negedge clk); sub_tick = 0;
      @(negedge clk); @(negedge clk);
      if (irq) begin n = i; break; end
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      sub_tick = 1; @(negedge clk); sub_tick = 0;
      @(negedge clk); @(negedge clk);
    end
  endtask

  task automatic wait_irq(input int lim);
    for (int i = 0; i < lim; i++) begin
      if (irq) break;
      @(negedge clk);
    end
  endtask

  // cycles between two successive flag sets, with ticks held continuously
  task automatic period(output int d);
    int t0;
    wait_irq(20000);
    t0 = cyc;
    ack();
    wait_irq(20000);
    d = cyc - t0;
  endtask

  task automatic start(input logic [7:0] mode, input logic [7:0] iv);
    wreg(1'b1, iv | 8'h80);
    wreg(1'b0, mode);
    wreg(1'b1, iv | 8'h80);
    ack();
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    int n;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);

    // R1 reset state
    rreg(1'b0, d); chk(d == 8'h00, "R1 mode reset", d, 0);
    rreg(1'b1, d); chk(d == 8'h00, "R1 counter reset", d, 0);
    chk(irq == 0, "R1 irq reset", irq, 0);

    // R1/R4 reset reload of 127: sub held, reload mode
    sub_tick = 1;
    wreg(1'b0, 8'h8C);
    period(n); chk(n == P_F * 128, "R1 R4 reload default 127", n, P_F * 128);
    sub_tick = 0;

    // R5 mode read-back
    wreg(1'b0, 8'h8E);
    rreg(1'b0, d); chk(d == 8'h8E, "R5 mode read", d, 8'h8E);

    // R3 interval selects with sub timebase held
    sub_tick = 1;
    start(8'h80, 8'h00); period(n); chk(n == P_S, "R3 interval 00", n, P_S);
    start(8'h84, 8'h00); period(n); chk(n == P_M, "R3 interval 01", n, P_M);
    start(8'h88, 8'h00); period(n); chk(n == P_F, "R3 interval 10", n, P_F);
    // R4 reload sweep
    for (int r = 0; r < 4; r++) begin
      start(8'h8C, 8'(r)); period(n);
      chk(n == P_F * (r + 1), "R4 reload period", n, P_F * (r + 1));
    end
    start(8'h8C, 8'd9); period(n); chk(n == P_F * 10, "R4 reload 9", n, P_F * 10);
    sub_tick = 0;

    // R2 divided timebases with main held
    main_tick = 1;
    for (int c = 1; c < 4; c++) begin
      int dv;
      dv = 1 << (DIV_W - (c - 1));
      start(8'h80 | 8'(c), 8'h00); period(n);
      chk(n == P_S * dv, "R2 main divider", n, P_S * dv);
    end
    // R2 main ticks ignored by sub select
    start(8'h80, 8'h00);
    repeat (P_S * 4) @(negedge clk);
    chk(irq == 0, "R2 sub select ignores main", irq, 0);
    main_tick = 0;

    // R8 exact first interval after clear, via single ticks
    start(8'h80, 8'h00);
    ticks_to_flag(100, n); chk(n == P_S, "R8 flag at interval end", n, P_S);

    // R9 clears
    wreg(1'b0, 8'h90);
    chk(irq == 1, "R9 write one keeps flag", irq, 1);
    wreg(1'b0, 8'h80);
    chk(irq == 0, "R9 write zero clears", irq, 0);
    wreg(1'b0, 8'h90);
    rreg(1'b0, d); chk(d == 8'h80, "R9 write one never sets", d, 8'h80);

    // R7 clear mid-interval restarts full interval
    start(8'h80, 8'h00);
    ticks(5);
    wreg(1'b1, 8'h80);
    ticks_to_flag(100, n); chk(n == P_S, "R7 clear restarts", n, P_S);

    // R5/R4 counter read after known wraps
    start(8'h8C, 8'd5);
    ticks(P_F * 3 + 10);
    rreg(1'b1, d); chk(d == 8'd3, "R5 counter read", d, 3);
    // R7 write without clear keeps counter
    wreg(1'b1, 8'd6);
    rreg(1'b1, d); chk(d == 8'd3, "R7 load without clear", d, 3);

    // R6 disable clears, re-enable starts full interval
    wreg(1'b0, 8'h0C);
    ticks(3);
    rreg(1'b1, d); chk(d == 8'd0, "R6 disabled counter zero", d, 0);
    ack();
    wreg(1'b0, 8'h80);
    ticks_to_flag(100, n); chk(n == P_S, "R6 restart full interval", n, P_S);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule